// File: doc/BRIEF.md
# Memory Copy to DMA Channel Program Translator

This block sits in front of a single memory-to-memory DMA channel pair (a source side and a destination side) and turns a plain copy request, made of a destination address, a source address and a byte length, into the sequence of channel register writes that carries the copy out. It picks the widest element size that the alignment of both addresses and the length allows. It runs the copy from the last element backwards whenever the source lies below the destination, so that overlapping regions are copied correctly. It cuts long copies into a part that is a whole number of 64 KiB blocks and a tail, and it uses two-dimensional transfers when one row would hold too many elements.

For each piece, the block waits until the channel is free, programs both sides, enables them and waits for the destination to report completion. It then clears the completion flag and disables both sides. A single-cycle completion pulse follows the cleanup of the last piece. Register writes leave the block as one command per cycle: a register code and a 32-bit value. Two status levels come back from the channel: destination done, and source enabled.

Top module: `dma_copy_xlate`

## Requirements
- R1: A request of length zero causes no register write, and the completion pulse is high in the first cycle after acceptance.
- R2: The element size is 4 bytes when destination, source and length are all multiples of 4, otherwise 2 bytes when all three are even, otherwise 1 byte. The configuration value carries the size code in bits 3:2 (0 = byte, 1 = halfword, 2 = word).
- R3: The step (modify) value is +size when the source address is not below the destination. Otherwise it is −size (32-bit two's complement), and both start addresses become address + length − size.
- R4: The element count is length / size. When the count exceeds 0x10000, two-dimensional mode is selected (configuration bit 4); otherwise the X count equals the element count.
- R5: In two-dimensional mode, with s = log2(size), the Y count is count >> (16 − s), the X count is 1 << (16 − s), and both Y modify registers equal the step value.
- R6: A request is split into a bulk part (length with its low 16 bits cleared), issued only when nonzero, followed by the remainder (low 16 bits) at address + bulk. A zero remainder after a bulk part is skipped.
- R7: While source-enabled is high and destination-done is low, no programming write of a new piece is issued.
- R8: Each piece is written in this order. Two-dimensional pieces start with the destination Y count, the source Y count, the destination Y modify and the source Y modify. Then come the destination address, X count, X modify and status (value 3), then the same four for the source side. Then the source configuration is written with bit 0 set, and the destination configuration is written with the same value plus bits 1 and 7. Register codes: source 0x0 address, 0x1 X count, 0x2 X modify, 0x3 Y count, 0x4 Y modify, 0x5 status, 0x6 configuration; destination codes are the same plus 0x8.
- R9: Once destination-done is seen after enabling, the block writes 3 to destination status, then 0 to source configuration, then 0 to destination configuration.
- R10: If source-enabled falls while waiting and destination-done is low, the piece ends with no cleanup writes and the block moves on.
- R11: When destination-done rises in the same cycle that source-enabled falls, the cleanup writes of R9 are issued.
- R12: A request is accepted only while ready is high, and ready is high only when idle. The completion pulse lasts one cycle and follows the last cleanup write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_dst | input | AW | Destination byte address |
| req_src | input | AW | Source byte address |
| req_len | input | LW | Length in bytes |
| dma_done | input | 1 | Destination side reports transfer complete |
| src_enabled | input | 1 | Source side configuration is nonzero |
| wr_valid | output | 1 | A register write command is present this cycle |
| wr_reg | output | 4 | Register code of the write |
| wr_data | output | 32 | Value to write |
| cmp_done | output | 1 | One-cycle pulse when the whole copy is finished |

## Verification
While the block waits for a piece to finish, the completion flag and the fall of the source enable can arrive in the same cycle. The two outcomes differ: one leads to cleanup writes, the other to abandoning the piece. The bench's channel model has a mode that drops the source enable on the exact edge where it raises done. It has another mode that drops the enable with no done. The scoreboard then expects cleanup writes in the first case and none in the second, and the next request is checked to start from a clean state.

// File: rtl/dmacp_pkg.sv
package dmacp_pkg;

   typedef enum logic [3:0] {
      RG_S_ADDR = 4'h0, RG_S_XCNT = 4'h1, RG_S_XMOD = 4'h2, RG_S_YCNT = 4'h3,
      RG_S_YMOD = 4'h4, RG_S_STAT = 4'h5, RG_S_CFG  = 4'h6,
      RG_D_ADDR = 4'h8, RG_D_XCNT = 4'h9, RG_D_XMOD = 4'hA, RG_D_YCNT = 4'hB,
      RG_D_YMOD = 4'hC, RG_D_STAT = 4'hD, RG_D_CFG  = 4'hE
   } chan_reg_e;

   localparam int CFG_EN      = 0;
   localparam int CFG_WNR     = 1;
   localparam int CFG_WID_LSB = 2;
   localparam int CFG_2D      = 4;
   localparam int CFG_IRQ     = 7;
   localparam logic [31:0] STAT_CLR = 32'h3;

   localparam int STEP_FIRST_2D = 0;
   localparam int STEP_FIRST_1D = 4;
   localparam int STEP_LAST_PRG = 13;
   localparam int STEP_FIRST_CL = 14;
   localparam int STEP_LAST_CL  = 16;

   typedef struct packed {
      logic [1:0]  shift;
      logic        is2d;
      logic [31:0] mod;
      logic [31:0] dst_start;
      logic [31:0] src_start;
      logic [31:0] xcnt;
      logic [31:0] ycnt;
   } plan_t;

endpackage

// File: rtl/dmacp_plan.sv
module dmacp_plan
   import dmacp_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 24
) (
   input  logic [AW-1:0] dst,
   input  logic [AW-1:0] src,
   input  logic [LW-1:0] len,
   output plan_t         plan
);
   localparam logic [31:0] ROW_MAX = 32'h0001_0000;

   logic          all4, all2, back;
   logic [1:0]    sh;
   logic [31:0]   esz;
   logic [AW-1:0] d_start, s_start;
   logic [31:0]   d_w, s_w;
   logic [LW-1:0] cnt;
   logic [4:0]    row_sh;

   always_comb begin
      all4   = ~|{dst[1:0], src[1:0], len[1:0]};
      all2   = ~|{dst[0], src[0], len[0]};
      sh     = all4 ? 2'd2 : (all2 ? 2'd1 : 2'd0);
      esz    = 32'd1 << sh;
      back   = src < dst;
      d_start = back ? dst + AW'(len) - AW'(esz) : dst;
      s_start = back ? src + AW'(len) - AW'(esz) : src;
      cnt    = len >> sh;
      row_sh = 5'd16 - {3'b0, sh};
   end

   generate
      if (AW == 32) begin : g_full
         assign d_w = d_start;
         assign s_w = s_start;
      end else begin : g_pad
         assign d_w = {{(32-AW){1'b0}}, d_start};
         assign s_w = {{(32-AW){1'b0}}, s_start};
      end
   endgenerate

   always_comb begin
      plan.shift     = sh;
      plan.is2d      = 32'(cnt) > ROW_MAX;
      plan.mod       = back ? (~esz + 32'd1) : esz;
      plan.dst_start = d_w;
      plan.src_start = s_w;
      if (plan.is2d) begin
         plan.ycnt = 32'(cnt >> row_sh);
         plan.xcnt = 32'd1 << row_sh;
      end else begin
         plan.ycnt = 32'd0;
         plan.xcnt = 32'(cnt);
      end
   end
endmodule

// File: rtl/dmacp_seq.sv
module dmacp_seq
   import dmacp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  plan_t       plan,
   input  logic        dma_done,
   input  logic        src_enabled,
   output logic        wr_valid,
   output logic [3:0]  wr_reg,
   output logic [31:0] wr_data,
   output logic        fin
);
   typedef enum logic [2:0] {Q_IDLE, Q_PRE, Q_PROG, Q_WAIT, Q_CLEAN} seq_e;

   seq_e        st;
   logic [4:0]  step;
   logic [31:0] s_cfg, d_cfg;
   chan_reg_e   rg;

   always_comb begin
      s_cfg = 32'd0;
      s_cfg[CFG_EN] = 1'b1;
      s_cfg[CFG_WID_LSB +: 2] = plan.shift;
      s_cfg[CFG_2D] = plan.is2d;
      d_cfg = s_cfg;
      d_cfg[CFG_WNR] = 1'b1;
      d_cfg[CFG_IRQ] = 1'b1;
   end

   assign fin = (st == Q_CLEAN && step == 5'(STEP_LAST_CL)) ||
                (st == Q_WAIT && !dma_done && !src_enabled);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= Q_IDLE;
         step <= '0;
      end else begin
         case (st)
            Q_IDLE: if (go) begin
               st   <= Q_PRE;
               step <= plan.is2d ? 5'(STEP_FIRST_2D) : 5'(STEP_FIRST_1D);
            end
            Q_PRE: if (!src_enabled || dma_done) st <= Q_PROG;
            Q_PROG: begin
               step <= step + 5'd1;
               if (step == 5'(STEP_LAST_PRG)) st <= Q_WAIT;
            end
            Q_WAIT: if (dma_done) st <= Q_CLEAN;
                    else if (!src_enabled) st <= Q_IDLE;
            Q_CLEAN: begin
               step <= step + 5'd1;
               if (step == 5'(STEP_LAST_CL)) st <= Q_IDLE;
            end
            default: st <= Q_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_valid = (st == Q_PROG) || (st == Q_CLEAN);
      rg       = RG_S_CFG;
      wr_data  = 32'd0;
      case (step)
         5'd0:  begin rg = RG_D_YCNT; wr_data = plan.ycnt;      end
         5'd1:  begin rg = RG_S_YCNT; wr_data = plan.ycnt;      end
         5'd2:  begin rg = RG_D_YMOD; wr_data = plan.mod;       end
         5'd3:  begin rg = RG_S_YMOD; wr_data = plan.mod;       end
         5'd4:  begin rg = RG_D_ADDR; wr_data = plan.dst_start; end
         5'd5:  begin rg = RG_D_XCNT; wr_data = plan.xcnt;      end
         5'd6:  begin rg = RG_D_XMOD; wr_data = plan.mod;       end
         5'd7:  begin rg = RG_D_STAT; wr_data = STAT_CLR;       end
         5'd8:  begin rg = RG_S_ADDR; wr_data = plan.src_start; end
         5'd9:  begin rg = RG_S_XCNT; wr_data = plan.xcnt;      end
         5'd10: begin rg = RG_S_XMOD; wr_data = plan.mod;       end
         5'd11: begin rg = RG_S_STAT; wr_data = STAT_CLR;       end
         5'd12: begin rg = RG_S_CFG;  wr_data = s_cfg;          end
         5'd13: begin rg = RG_D_CFG;  wr_data = d_cfg;          end
         5'd14: begin rg = RG_D_STAT; wr_data = STAT_CLR;       end
         5'd15: begin rg = RG_S_CFG;  wr_data = 32'd0;          end
         5'd16: begin rg = RG_D_CFG;  wr_data = 32'd0;          end
         default: begin rg = RG_S_CFG; wr_data = 32'd0;         end
      endcase
      wr_reg = rg;
   end
endmodule

// File: rtl/dma_copy_xlate.sv
module dma_copy_xlate
   import dmacp_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_dst,
   input  logic [AW-1:0] req_src,
   input  logic [LW-1:0] req_len,
   input  logic          dma_done,
   input  logic          src_enabled,
   output logic          wr_valid,
   output logic [3:0]    wr_reg,
   output logic [31:0]   wr_data,
   output logic          cmp_done
);
   localparam int BLK_W = 16;

   generate
      if (LW <= BLK_W || LW > AW || AW > 32) begin : g_bad_cfg
         $error("dma_copy_xlate: need 16 < LW <= AW <= 32");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_RUN, T_FIN} top_e;

   top_e          st;
   logic          go_q, has_rest, seq_fin;
   logic [AW-1:0] cur_dst, cur_src, rest_dst, rest_src;
   logic [LW-1:0] cur_len, rest_len, bulk, tail;
   plan_t         plan;

   assign bulk = {req_len[LW-1:BLK_W], {BLK_W{1'b0}}};
   assign tail = {{(LW-BLK_W){1'b0}}, req_len[BLK_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= T_IDLE;
         go_q     <= 1'b0;
         has_rest <= 1'b0;
         cur_dst  <= '0;
         cur_src  <= '0;
         cur_len  <= '0;
         rest_dst <= '0;
         rest_src <= '0;
         rest_len <= '0;
      end else begin
         go_q <= 1'b0;
         case (st)
            T_IDLE: if (req_valid) begin
               if (req_len == '0) begin
                  st <= T_FIN;
               end else begin
                  st      <= T_RUN;
                  go_q    <= 1'b1;
                  cur_dst <= req_dst;
                  cur_src <= req_src;
                  if (bulk != '0) begin
                     cur_len  <= bulk;
                     has_rest <= tail != '0;
                  end else begin
                     cur_len  <= tail;
                     has_rest <= 1'b0;
                  end
                  rest_dst <= req_dst + AW'(bulk);
                  rest_src <= req_src + AW'(bulk);
                  rest_len <= tail;
               end
            end
            T_RUN: if (seq_fin) begin
               if (has_rest) begin
                  has_rest <= 1'b0;
                  go_q     <= 1'b1;
                  cur_dst  <= rest_dst;
                  cur_src  <= rest_src;
                  cur_len  <= rest_len;
               end else begin
                  st <= T_FIN;
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   assign req_ready = (st == T_IDLE);
   assign cmp_done  = (st == T_FIN);

   dmacp_plan #(.AW(AW), .LW(LW)) u_plan (
      .dst(cur_dst), .src(cur_src), .len(cur_len), .plan(plan)
   );

   dmacp_seq u_seq (
      .clk(clk), .rst_n(rst_n), .go(go_q), .plan(plan),
      .dma_done(dma_done), .src_enabled(src_enabled),
      .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_data(wr_data), .fin(seq_fin)
   );
endmodule

// File: rtl/dmacp_chk.sv
module dmacp_chk
   import dmacp_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        dma_done,
   input logic        src_enabled,
   input logic        wr_valid,
   input logic [3:0]  wr_reg,
   input logic [31:0] wr_data,
   input logic        cmp_done
);
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done |=> !cmp_done); // R12
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R12
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !wr_valid); // R12
   AST_PREWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !$past(wr_valid) |-> $past(!src_enabled || dma_done)); // R7
   AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_reg == RG_S_CFG && wr_data != 32'd0 |-> wr_data[3:2] != 2'b11); // R2
   AST_DST_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_reg == RG_D_CFG && wr_data[0] |-> $past(wr_valid && wr_reg == RG_S_CFG)); // R8
   AST_CLEAN_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_reg == RG_S_CFG && wr_data == 32'd0 |-> $past(wr_valid && wr_reg == RG_D_STAT)); // R9
endmodule

bind dma_copy_xlate dmacp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .dma_done(dma_done), .src_enabled(src_enabled), .wr_valid(wr_valid),
   .wr_reg(wr_reg), .wr_data(wr_data), .cmp_done(cmp_done)
);

// File: tb/tb_dma_copy_xlate.sv
module tb_dma_copy_xlate;
   localparam int AW = 32;
   localparam int LW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_dst = '0, req_src = '0;
   logic [LW-1:0] req_len = '0;
   logic req_ready, wr_valid, cmp_done;
   logic [3:0] wr_reg;
   logic [31:0] wr_data;
   logic src_en_m = 1'b0, done_m = 1'b0, forced_busy = 1'b0;
   logic dma_done, src_enabled;
   int   lat_cnt = 0;
   int   mode = 0;
   int   lat = 5;

   always #2 clk = ~clk;

   assign dma_done    = done_m;
   assign src_enabled = src_en_m | forced_busy;

   dma_copy_xlate #(.AW(AW), .LW(LW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_dst(req_dst), .req_src(req_src), .req_len(req_len),
      .dma_done(dma_done), .src_enabled(src_enabled), .wr_valid(wr_valid),
      .wr_reg(wr_reg), .wr_data(wr_data), .cmp_done(cmp_done)
   );

   // channel model: mode 0 normal, 1 done with enable drop, 2 enable drop only
   always @(posedge clk) begin
      if (!rst_n) begin
         src_en_m <= 1'b0; done_m <= 1'b0; lat_cnt <= 0;
      end else begin
         if (wr_valid && wr_reg == 4'h6) src_en_m <= (wr_data != 0);
         if (wr_valid && wr_reg == 4'hD) done_m <= 1'b0;
         if (wr_valid && wr_reg == 4'hE && wr_data != 0) lat_cnt <= lat;
         else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
               if (mode == 2) src_en_m <= 1'b0;
               else begin
                  done_m <= 1'b1;
                  if (mode == 1) src_en_m <= 1'b0;
               end
            end
         end
      end
   end

   typedef struct { logic [3:0] r; logic [31:0] d; string tag; } item_t;
   item_t exp_q[$];

   int d_checks = 0, d_fails = 0, m_checks = 0, m_fails = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      d_checks++;
      if (!ok) begin
         d_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         m_checks++;
         if (exp_q.size() == 0) begin
            m_fails++;
            $display("FAIL R8 unexpected write actual=reg%0h:0x%0h expected=none", wr_reg, wr_data);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            if (it.r !== wr_reg || it.d !== wr_data) begin
               m_fails++;
               $display("FAIL %s actual=reg%0h:0x%0h expected=reg%0h:0x%0h",
                        it.tag, wr_reg, wr_data, it.r, it.d);
            end
         end
      end
   end

   task automatic push(input logic [3:0] r, input logic [31:0] d, input string tag);
      item_t it;
      it.r = r; it.d = d; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic add_piece(input logic [31:0] d, input logic [31:0] s, input logic [31:0] n);
      int sh;
      logic [31:0] esz, md, ds, ss, cnt, xc, yc, cfg;
      bit back, twod;
      if (d % 4 == 0 && s % 4 == 0 && n % 4 == 0) sh = 2;
      else if (d % 2 == 0 && s % 2 == 0 && n % 2 == 0) sh = 1;
      else sh = 0;
      esz  = 32'd1 << sh;
      back = s < d;
      md   = back ? -esz : esz;
      ds   = back ? d + n - esz : d;
      ss   = back ? s + n - esz : s;
      cnt  = n >> sh;
      twod = cnt > 32'h10000;
      xc   = twod ? (32'd1 << (16 - sh)) : cnt;
      yc   = cnt >> (16 - sh);
      cfg  = 32'd1 | (32'(sh) << 2) | (twod ? 32'h10 : 32'h0);
      if (twod) begin
         push(4'hB, yc, "R5"); push(4'h3, yc, "R5");
         push(4'hC, md, "R5"); push(4'h4, md, "R5");
      end
      push(4'h8, ds, "R3"); push(4'h9, xc, "R4"); push(4'hA, md, "R3"); push(4'hD, 3, "R8");
      push(4'h0, ss, "R3"); push(4'h1, xc, "R4"); push(4'h2, md, "R3"); push(4'h5, 3, "R8");
      push(4'h6, cfg, "R2"); push(4'hE, cfg | 32'h82, "R8");
      if (mode != 2) begin
         push(4'hD, 3, mode == 1 ? "R11" : "R9");
         push(4'h6, 0, mode == 1 ? "R11" : "R9");
         push(4'hE, 0, mode == 1 ? "R11" : "R9");
      end else begin
         check(1'b1, "R10", 0, 0);
      end
   endtask

   task automatic run_req(input logic [31:0] d, input logic [31:0] s, input logic [31:0] n,
                          input int hold);
      logic [31:0] bulk, rest;
      int waited;
      int early;
      bulk = n & ~32'hFFFF;
      rest = n & 32'hFFFF;
      if (bulk != 0) add_piece(d, s, bulk);
      if (rest != 0) add_piece(d + bulk, s + bulk, rest);
      @(negedge clk);
      if (hold > 0) forced_busy = 1'b1;
      check(req_ready === 1'b1, "R12 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_dst = d; req_src = s; req_len = n[LW-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready === 1'b0, "R12 busy after accept", req_ready, 0);
      if (n == 0) check(cmp_done === 1'b1, "R1 immediate completion", cmp_done, 1);
      if (hold > 0) begin
         early = 0;
         for (int i = 0; i < hold; i++) begin
            if (wr_valid) early++;
            @(negedge clk);
         end
         check(early == 0, "R7 no write while channel busy", early, 0);
         forced_busy = 1'b0;
      end
      waited = 0;
      while (cmp_done !== 1'b1 && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      check(cmp_done === 1'b1, "R12 completion pulse", cmp_done, 1);
      check(exp_q.size() == 0, n == 0 ? "R1 no writes" : "R6 all pieces written",
            exp_q.size(), 0);
      @(negedge clk);
      check(cmp_done === 1'b0, "R12 pulse one cycle", cmp_done, 0);
      check(req_ready === 1'b1, "R12 ready again", req_ready, 1);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", (d_checks + m_checks) - (d_fails + m_fails),
                  d_checks + m_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      d_checks++; d_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1 && wr_valid === 1'b0 && cmp_done === 1'b0,
            "R12 reset state", {req_ready, wr_valid, cmp_done}, 3'b100);
      run_req(32'h1000, 32'h2000, 0, 0);              // R1 zero length
      run_req(32'h1000, 32'h2000, 32'h40, 0);         // R2 word forward
      run_req(32'h1002, 32'h3000, 32'h22, 0);         // R2 halfword
      run_req(32'h2001, 32'h2000, 7, 0);              // R3 byte backward overlap
      run_req(32'h5000, 32'h4000, 32'h100, 0);        // R3 word backward
      run_req(32'h10000, 32'h40000, 32'h10010, 0);    // R6 bulk plus tail
      run_req(32'h100001, 32'h300000, 32'h40000, 0);  // R5 2D byte, R6 tail skipped
      run_req(32'h200000, 32'h100000, 32'h80004, 0);  // R5 2D word backward
      run_req(32'h3, 32'h7, 32'h10000, 0);            // R4 count exactly 0x10000
      run_req(32'h8000, 32'h9000, 32'h30, 12);        // R7 prewait
      mode = 2;
      run_req(32'hA000, 32'hB000, 32'h20, 0);         // R10 abandon
      mode = 1;
      run_req(32'hC000, 32'hD000, 32'h24, 0);         // R11 same-cycle done/disable
      mode = 0;
      run_req(32'h6000, 32'h6004, 32'h18, 0);         // follow-up clean start
      repeat (4) @(negedge clk);
      summary();
   end
endmodule